// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a flash device. It works out when an embedded program or erase operation inside the device has finished. After a start pulse it reads a status location again and again over a simple request/acknowledge read port. It compares the toggle bit of each status byte with the same bit of the byte before it. If the bit stops changing, the operation has finished. If the bit keeps changing while the error bit is raised, two more reads decide whether the device really failed. For an erase, any address inside the sector being erased can serve as the polling address.

When the operation succeeds and a check is requested, one further read fetches the target location. That byte is compared with the intended value. A guard on the number of polls ends a run that never settles. Each run ends with a one-cycle done pulse and a set of result flags that stay valid until the next start.

Top module: `tglpoll_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `rd_req`, `done`, `pass`, `fail`, `verify_error` and `timeout_error` are all 0.
- R2: A start pulse seen while idle raises `busy` and, on the next cycle, `rd_req` with `rd_addr` equal to `poll_addr`. Every read keeps `rd_req` high and `rd_addr` steady until the cycle in which `rd_ack` is high, and the data is taken in that cycle.
- R3: If bit 6 of a status byte equals bit 6 of the status byte read just before it, the run passes. This holds whatever the value of bit 5.
- R4: If bit 6 changed and bit 5 is 0, another status read is issued at the same polling address.
- R5: If bit 6 changed and bit 5 is 1, exactly two more status reads follow. The run fails if bit 6 differs between those two reads, and passes otherwise.
- R6: When `verify_en` was set at start, a successful run issues one read at `verify_addr`. The run passes if all 8 bits equal `verify_data`. Otherwise it fails with `verify_error` set.
- R7: Each poll that finds bit 6 changed with bit 5 at 0 counts as one unsettled poll. When this count reaches `max_polls` (a value of 0 acts as 1), the run fails with `timeout_error` set and no further read is issued. A poll that settles on that same read passes instead.
- R8: A run ends with `done` high for exactly one cycle, with `busy` low in that cycle and exactly one of `pass` and `fail` high. The result flags hold until the next accepted start.
- R9: A start pulse while `busy` is high is ignored. The polling address, the number of reads and the result of the run in progress are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, taken only while idle |
| poll_addr | input | ADDR_W | Status polling address, latched at start |
| verify_en | input | 1 | Request a final compare read, latched at start |
| verify_addr | input | ADDR_W | Target location for the compare read |
| verify_data | input | DATA_W | Intended byte for the compare read |
| max_polls | input | CNT_W | Limit on unsettled polls |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read acknowledge; data is valid in the same cycle |
| rd_data | input | DATA_W | Read data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run succeeded |
| fail | output | 1 | Run failed |
| verify_error | output | 1 | Failure came from the compare read |
| timeout_error | output | 1 | Failure came from the poll limit |

## Verification
The assertions watch, on every cycle, the read handshake rules (request held, address stable), the shape of the done pulse, and the consistency of the result flags: exactly one of pass and fail, and each error flag always paired with fail. Which outcome a given status sequence leads to can only be shown by the bench scenarios. That covers settling on an unchanged toggle bit, the two confirming reads after the error bit, the compare read, the poll limit at and just before its boundary, and a restart attempt during a run. Each scenario is checked against the number of reads issued and the addresses they used.

// File: rtl/tglpoll_pkg.sv
package tglpoll_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEED,
      ST_POLL,
      ST_CONF_A,
      ST_CONF_B,
      ST_VERIFY
   } poll_state_e;

   typedef enum logic [1:0] {
      CLS_STEADY,
      CLS_RUNNING,
      CLS_ERRFLAG
   } status_cls_e;

endpackage

// File: rtl/tglpoll_rdport.sv
module tglpoll_rdport #(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter bit REG_RESP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [ADDR_W-1:0] issue_addr,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   output logic              beat,
   output logic [DATA_W-1:0] beat_data
);

   logic              req_q;
   logic [ADDR_W-1:0] addr_q;
   logic              accept;

   assign accept  = req_q & rd_ack;
   assign rd_req  = req_q;
   assign rd_addr = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         addr_q <= '0;
      end else if (issue) begin
         req_q  <= 1'b1;
         addr_q <= issue_addr;
      end else if (accept) begin
         req_q  <= 1'b0;
      end
   end

   generate
      if (REG_RESP) begin : g_reg_resp
         logic              beat_q;
         logic [DATA_W-1:0] data_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               beat_q <= 1'b0;
               data_q <= '0;
            end else begin
               beat_q <= accept;
               if (accept) data_q <= rd_data;
            end
         end
         assign beat      = beat_q;
         assign beat_data = data_q;
      end else begin : g_comb_resp
         assign beat      = accept;
         assign beat_data = rd_data;
      end
   endgenerate

endmodule

// File: rtl/tglpoll_classify.sv
module tglpoll_classify
   import tglpoll_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int TGL_BIT = 6,
   parameter int ERR_BIT = 5
) (
   input  logic              prev_tgl,
   input  logic [DATA_W-1:0] status,
   output logic              cur_tgl,
   output status_cls_e       cls
);

   logic moved;

   assign cur_tgl = status[TGL_BIT];
   assign moved   = cur_tgl ^ prev_tgl;

   always_comb begin
      if (!moved)                cls = CLS_STEADY;
      else if (status[ERR_BIT])  cls = CLS_ERRFLAG;
      else                       cls = CLS_RUNNING;
   end

endmodule

// File: rtl/tglpoll_limit.sv
module tglpoll_limit #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] limit_in,
   input  logic             bump,
   output logic             last
);

   localparam int EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit_q;
   logic [EXT_W-1:0] next_ext;

   assign next_ext = {1'b0, cnt_q} + EXT_W'(1);
   assign last     = next_ext >= {1'b0, limit_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         limit_q <= '0;
      end else if (load) begin
         cnt_q   <= '0;
         limit_q <= limit_in;
      end else if (bump && !next_ext[CNT_W]) begin
         cnt_q   <= next_ext[CNT_W-1:0];
      end
   end

endmodule

// File: rtl/tglpoll_ctrl.sv
module tglpoll_ctrl
   import tglpoll_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 16,
   parameter int TGL_BIT  = 6,
   parameter int ERR_BIT  = 5,
   parameter bit REG_RESP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] poll_addr,
   input  logic              verify_en,
   input  logic [ADDR_W-1:0] verify_addr,
   input  logic [DATA_W-1:0] verify_data,
   input  logic [CNT_W-1:0]  max_polls,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic              fail,
   output logic              verify_error,
   output logic              timeout_error
);

   generate
      if (TGL_BIT >= DATA_W || ERR_BIT >= DATA_W || TGL_BIT == ERR_BIT) begin : g_bad_bits
         $error("tglpoll_ctrl: status bit positions invalid");
      end
      if (CNT_W < 1 || ADDR_W < 1) begin : g_bad_width
         $error("tglpoll_ctrl: widths must be positive");
      end
   endgenerate

   poll_state_e       state_q, state_d;
   logic              issue;
   logic [ADDR_W-1:0] issue_addr;
   logic              beat;
   logic [DATA_W-1:0] beat_data;
   logic              prev_tgl_q;
   logic              cur_tgl;
   status_cls_e       cls;
   logic              seed_ld;
   logic              cnt_load, cnt_bump, cnt_last;
   logic              settled;
   logic              fin, fin_pass, fin_verr, fin_tmo;

   logic [ADDR_W-1:0] paddr_q, vaddr_q;
   logic              ven_q;
   logic [DATA_W-1:0] vdata_q;
   logic              done_q, pass_q, fail_q, verr_q, tmo_q;

   tglpoll_rdport #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .REG_RESP (REG_RESP)
   ) u_rdport (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (issue),
      .issue_addr (issue_addr),
      .rd_req     (rd_req),
      .rd_addr    (rd_addr),
      .rd_ack     (rd_ack),
      .rd_data    (rd_data),
      .beat       (beat),
      .beat_data  (beat_data)
   );

   tglpoll_classify #(
      .DATA_W  (DATA_W),
      .TGL_BIT (TGL_BIT),
      .ERR_BIT (ERR_BIT)
   ) u_classify (
      .prev_tgl (prev_tgl_q),
      .status   (beat_data),
      .cur_tgl  (cur_tgl),
      .cls      (cls)
   );

   tglpoll_limit #(
      .CNT_W (CNT_W)
   ) u_limit (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .limit_in (max_polls),
      .bump     (cnt_bump),
      .last     (cnt_last)
   );

   always_comb begin
      state_d    = state_q;
      issue      = 1'b0;
      issue_addr = paddr_q;
      seed_ld    = 1'b0;
      cnt_load   = 1'b0;
      cnt_bump   = 1'b0;
      settled    = 1'b0;
      fin        = 1'b0;
      fin_pass   = 1'b0;
      fin_verr   = 1'b0;
      fin_tmo    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               state_d    = ST_SEED;
               issue      = 1'b1;
               issue_addr = poll_addr;
               cnt_load   = 1'b1;
            end
         end
         ST_SEED: begin
            if (beat) begin
               seed_ld = 1'b1;
               state_d = ST_POLL;
               issue   = 1'b1;
            end
         end
         ST_POLL: begin
            if (beat) begin
               seed_ld = 1'b1;
               unique case (cls)
                  CLS_STEADY: settled = 1'b1;
                  CLS_ERRFLAG: begin
                     state_d = ST_CONF_A;
                     issue   = 1'b1;
                  end
                  default: begin
                     cnt_bump = 1'b1;
                     if (cnt_last) begin
                        fin     = 1'b1;
                        fin_tmo = 1'b1;
                     end else begin
                        issue = 1'b1;
                     end
                  end
               endcase
            end
         end
         ST_CONF_A: begin
            if (beat) begin
               seed_ld = 1'b1;
               state_d = ST_CONF_B;
               issue   = 1'b1;
            end
         end
         ST_CONF_B: begin
            if (beat) begin
               if (cls == CLS_STEADY) settled = 1'b1;
               else                   fin     = 1'b1;
            end
         end
         ST_VERIFY: begin
            if (beat) begin
               fin      = 1'b1;
               fin_pass = (beat_data == vdata_q);
               fin_verr = (beat_data != vdata_q);
            end
         end
         default: state_d = ST_IDLE;
      endcase

      if (settled) begin
         if (ven_q) begin
            state_d    = ST_VERIFY;
            issue      = 1'b1;
            issue_addr = vaddr_q;
         end else begin
            fin      = 1'b1;
            fin_pass = 1'b1;
         end
      end
      if (fin) state_d = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         prev_tgl_q <= 1'b0;
         paddr_q    <= '0;
         vaddr_q    <= '0;
         ven_q      <= 1'b0;
         vdata_q    <= '0;
      end else begin
         state_q <= state_d;
         if (seed_ld) prev_tgl_q <= cur_tgl;
         if (state_q == ST_IDLE && start) begin
            paddr_q <= poll_addr;
            vaddr_q <= verify_addr;
            ven_q   <= verify_en;
            vdata_q <= verify_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         pass_q <= 1'b0;
         fail_q <= 1'b0;
         verr_q <= 1'b0;
         tmo_q  <= 1'b0;
      end else begin
         done_q <= fin;
         if (fin) begin
            pass_q <= fin_pass;
            fail_q <= ~fin_pass;
            verr_q <= fin_verr;
            tmo_q  <= fin_tmo;
         end else if (state_q == ST_IDLE && start) begin
            pass_q <= 1'b0;
            fail_q <= 1'b0;
            verr_q <= 1'b0;
            tmo_q  <= 1'b0;
         end
      end
   end

   assign busy          = (state_q != ST_IDLE);
   assign done          = done_q;
   assign pass          = pass_q;
   assign fail          = fail_q;
   assign verify_error  = verr_q;
   assign timeout_error = tmo_q;

endmodule

// File: rtl/tglpoll_ctrl_chk.sv
module tglpoll_ctrl_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              rd_req,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_ack,
   input logic              busy,
   input logic              done,
   input logic              pass,
   input logic              fail,
   input logic              verify_error,
   input logic              timeout_error
);

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_ack |=> rd_req && $stable(rd_addr)); // R2

   AST_START_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy && rd_req); // R2

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_req); // R1

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && (pass ^ fail)); // R8

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass && fail)); // R8

   AST_VERR_IS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      verify_error |-> fail && !timeout_error); // R6

   AST_TMO_IS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_error |-> fail); // R7

   AST_BUSY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done && start && $past(busy) |=> $stable(rd_addr) || !rd_req || $past(rd_ack)); // R9

endmodule

bind tglpoll_ctrl tglpoll_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start         (start),
   .rd_req        (rd_req),
   .rd_addr       (rd_addr),
   .rd_ack        (rd_ack),
   .busy          (busy),
   .done          (done),
   .pass          (pass),
   .fail          (fail),
   .verify_error  (verify_error),
   .timeout_error (timeout_error)
);

// File: tb/tglpoll_ctrl_test.sv
module tglpoll_ctrl_test;

   localparam int AW = 16;
   localparam int DW = 8;
   localparam int CW = 16;
   localparam logic [AW-1:0] VADDR = 16'h2000;

   typedef struct packed {
      logic        e_pass;
      logic        e_verr;
      logic        e_tmo;
      logic [15:0] e_reads;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] poll_addr = '0;
   logic          verify_en = 1'b0;
   logic [AW-1:0] verify_addr = '0;
   logic [DW-1:0] verify_data = '0;
   logic [CW-1:0] max_polls = '0;
   logic          rd_req;
   logic [AW-1:0] rd_addr;
   logic          rd_ack = 1'b0;
   logic [DW-1:0] rd_data = '0;
   logic          busy, done, pass, fail, verify_error, timeout_error;

   int checks = 0;
   int fails  = 0;
   int res_cnt = 0;
   int nreads = 0;
   int lat = 0;
   int wcnt = 0;
   logic [AW-1:0] cur_paddr = '0;
   logic [DW-1:0] mem_val = '0;
   logic [DW-1:0] stat_q[$];
   exp_t          exp_q[$];
   string         tag_q[$];

   always #2.5 clk = ~clk;

   tglpoll_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .poll_addr(poll_addr),
      .verify_en(verify_en), .verify_addr(verify_addr), .verify_data(verify_data),
      .max_polls(max_polls), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
      .rd_data(rd_data), .busy(busy), .done(done), .pass(pass), .fail(fail),
      .verify_error(verify_error), .timeout_error(timeout_error)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // Flash model: serves one read per falling edge with rd_req high, after lat idle edges
   always @(negedge clk) begin
      rd_ack = 1'b0;
      if (rst_n && rd_req) begin
         if (wcnt >= lat) begin
            wcnt = 0;
            rd_ack = 1'b1;
            nreads++;
            if (rd_addr == VADDR) begin
               rd_data = mem_val;
            end else begin
               check(rd_addr == cur_paddr, "R2", "poll address", rd_addr, cur_paddr);
               if (stat_q.size() == 0) begin
                  check(1'b0, "R4", "extra status read", nreads, 0);
                  rd_data = 8'hFF;
               end else begin
                  rd_data = stat_q.pop_front();
               end
            end
         end else begin
            wcnt++;
         end
      end
   end

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R8", "unexpected done", 1, 0);
         end else begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(pass == e.e_pass, t, "pass", pass, e.e_pass);
            check(fail == !e.e_pass, t, "fail", fail, !e.e_pass);
            check(verify_error == e.e_verr, t, "verify_error", verify_error, e.e_verr);
            check(timeout_error == e.e_tmo, t, "timeout_error", timeout_error, e.e_tmo);
            check(nreads == int'(e.e_reads), t, "read count", nreads, e.e_reads);
            check(!busy, "R8", "busy at done", busy, 0);
         end
         res_cnt++;
      end
   end

   task automatic run_case(input string tag, input logic [AW-1:0] pa, input int lim,
                           input bit ven, input logic [DW-1:0] vd, input logic [DW-1:0] mv,
                           input int lat_i, input bit e_pass, input bit e_verr,
                           input bit e_tmo, input int e_reads, input bit restart);
      int   n0;
      exp_t e;
      n0 = res_cnt;
      @(negedge clk);
      cur_paddr = pa;
      mem_val   = mv;
      lat       = lat_i;
      wcnt      = 0;
      nreads    = 0;
      e.e_pass  = e_pass;
      e.e_verr  = e_verr;
      e.e_tmo   = e_tmo;
      e.e_reads = 16'(e_reads);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      poll_addr   = pa;
      max_polls   = CW'(lim);
      verify_en   = ven;
      verify_addr = VADDR;
      verify_data = vd;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (restart) begin
         repeat (4) @(negedge clk);
         check(busy, "R9", "busy before restart", busy, 1);
         poll_addr = 16'h1FFF;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (res_cnt == n0) @(negedge clk);
      repeat (2) @(negedge clk);
      check(pass == e_pass && fail == !e_pass, "R8", "flags held", pass, e_pass);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !rd_req && !done, "R1", "idle outputs", {busy, rd_req, done}, 0);
      check(!pass && !fail, "R1", "result flags", {pass, fail}, 0);
      check(!verify_error && !timeout_error, "R1", "error flags", {verify_error, timeout_error}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!busy && !rd_req, "R1", "idle after release", {busy, rd_req}, 0);

      // R3: unchanged toggle bit on second read
      stat_q = '{8'h40, 8'h40};
      run_case("R3", 16'h1000, 10, 1'b0, 8'h00, 8'h00, 0, 1'b1, 1'b0, 1'b0, 2, 1'b0);
      // R3: error bit set but toggle bit steady still passes
      stat_q = '{8'h20, 8'h20};
      run_case("R3", 16'h1004, 10, 1'b0, 8'h00, 8'h00, 2, 1'b1, 1'b0, 1'b0, 2, 1'b0);
      // R4: toggling a while, then settles
      stat_q = '{8'h40, 8'h00, 8'h40, 8'h00, 8'h00};
      run_case("R4", 16'h1010, 10, 1'b0, 8'h00, 8'h00, 1, 1'b1, 1'b0, 1'b0, 5, 1'b0);
      // R5: error bit, confirming reads still toggle
      stat_q = '{8'h00, 8'h60, 8'h20, 8'h60};
      run_case("R5", 16'h1020, 10, 1'b0, 8'h00, 8'h00, 0, 1'b0, 1'b0, 1'b0, 4, 1'b0);
      // R5 + R6: error bit, confirming reads steady, compare matches
      stat_q = '{8'h00, 8'h60, 8'h20, 8'h20};
      run_case("R6", 16'h1030, 10, 1'b1, 8'h5A, 8'h5A, 1, 1'b1, 1'b0, 1'b0, 5, 1'b0);
      // R6: compare mismatch
      stat_q = '{8'h40, 8'h40};
      run_case("R6", 16'h1040, 10, 1'b1, 8'h5A, 8'h5B, 0, 1'b0, 1'b1, 1'b0, 3, 1'b0);
      // R7: limit reached while still toggling
      stat_q = '{8'h00, 8'h40, 8'h00, 8'h40};
      run_case("R7", 16'h1050, 3, 1'b0, 8'h00, 8'h00, 0, 1'b0, 1'b0, 1'b1, 4, 1'b0);
      // R7: settles on the read that would hit the limit
      stat_q = '{8'h00, 8'h40, 8'h00, 8'h00};
      run_case("R7", 16'h1060, 3, 1'b0, 8'h00, 8'h00, 2, 1'b1, 1'b0, 1'b0, 4, 1'b0);
      // R7: limit 0 acts as 1
      stat_q = '{8'h00, 8'h40};
      run_case("R7", 16'h1070, 0, 1'b0, 8'h00, 8'h00, 0, 1'b0, 1'b0, 1'b1, 2, 1'b0);
      // R9: start during a run is ignored
      stat_q = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h40};
      run_case("R9", 16'h1080, 10, 1'b0, 8'h00, 8'h00, 3, 1'b1, 1'b0, 1'b0, 5, 1'b1);
      check(stat_q.size() == 0, "R9", "status reads used", stat_q.size(), 0);

      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R8 watchdog: actual %0d expected %0d", res_cnt, exp_q.size());
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule